// File: doc/BRIEF.md
# Target-Cycle Timing Delay Connector

This block is the channel between two modules of a cycle-level timing model that runs on host hardware. One simulated target cycle spans a variable number of host clock cycles. A producer module pushes tokens in, and a consumer module peeks at and pops the oldest token, as it would with an ordinary FIFO. The connector, not the modules, imposes the target machine's timing:

- a cap on how many tokens may enter per target cycle;
- a cap on how many may leave per target cycle;
- a minimum transit time counted in target cycles;
- a limit on the number of tokens held at once.

A module such as an ALU model can therefore pass tokens straight through, and its latency lives entirely in the connector. All entries are interchangeable, and a design with separate lanes uses one connector per lane.

Each side raises a commit pulse when it has finished its work for the current target cycle. Once both commits have been seen, the connector signals done to both sides and steps its target-cycle counter. This also opens fresh per-cycle budgets.

The connector also keeps occupancy and stall statistics. It has a trace memory that, once triggered, stores one record per completed target cycle.

Top module: `tm_delay_link`

## Requirements
- R1: After reset, occupancy, peak occupancy, stall count, target cycle, trace count, enq_ok, first_valid and both done outputs are all zero.
- R2: An enqueue is accepted (enq_ok high, combinationally) exactly when all of the following hold: enq_valid is high, the producer has not committed in this target cycle, occupancy is below DEPTH, and fewer than IN_TP enqueues have been accepted in this target cycle. Occupancy never exceeds DEPTH. A dequeue in the same host cycle does not free room for that cycle's enqueue.
- R3: A token accepted while the target cycle counter equals t can be presented at first_valid only when the counter minus t (modulo 2^TCW) is at least DELAY.
- R4: At most OUT_TP tokens leave per target cycle. A deq while first_valid is low, or after the consumer has committed, is ignored: it removes nothing.
- R5: prod_done and cons_done are both high exactly in the host cycles where both sides have committed in the current target cycle. At the end of each such cycle, the target cycle counter increments by one, and the per-cycle enqueue and dequeue budgets, along with both commit records, are cleared.
- R6: Repeated commit pulses from a side within one target cycle have no further effect. The counter advances once per target cycle.
- R7: stall_cnt increments by one for every host cycle in which enq_valid is high, the producer has not committed, and the enqueue is refused.
- R8: peak_occ equals the largest value occupancy has shown at any earlier clock edge since reset.
- R9: After trig is seen, each target-cycle advance writes one record into the trace memory at index trace_count, until TRACE_DEPTH (default 512) records exist. The record is, MSB first: {target cycle, enqueues this cycle, dequeues this cycle, occupancy}. With the default parameters, these fields are 16, 2, 1 and 3 bits wide. trace_rd_data reads the memory combinationally at trace_rd_addr.
- R10: Tokens leave in the order they were accepted, and first_data shows the oldest token whenever first_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Producer offers a token |
| enq_data | input | DW | Token payload |
| enq_ok | output | 1 | Offered token is taken this host cycle |
| first_valid | output | 1 | Oldest token may be consumed now |
| first_data | output | DW | Oldest token |
| deq | input | 1 | Consumer pops the oldest token |
| prod_commit | input | 1 | Producer finished the current target cycle |
| cons_commit | input | 1 | Consumer finished the current target cycle |
| prod_done | output | 1 | Connector finished the current target cycle (producer side) |
| cons_done | output | 1 | Connector finished the current target cycle (consumer side) |
| tcycle | output | TCW | Target cycle counter |
| occupancy | output | CW | Tokens held |
| peak_occ | output | CW | Highest occupancy observed |
| stall_cnt | output | SCW | Refused enqueue attempts |
| trig | input | 1 | Starts trace capture |
| trace_rd_addr | input | TAW | Trace read index |
| trace_rd_data | output | RW | Trace record at trace_rd_addr |
| trace_count | output | TAW+1 | Records captured |

## Verification
The embedded properties assume that the target cycle counter does not wrap within a token's lifetime. This means DELAY plus the longest residence time must stay far below 2^TCW target cycles. The stimulus runs only a few hundred target cycles. The properties also assume that commit pulses may arrive in any host cycle, including repeats. The bench therefore drives commits, offers and pops independently at random each host cycle, with phase-dependent rates that alternately saturate the queue and drain it. The run lasts past 512 target cycles, so the trace memory is seen to stop filling.

// File: rtl/tm_delay_link.sv
module tm_delay_link #(
  parameter int DW = 8,
  parameter int DEPTH = 4,
  parameter int IN_TP = 2,
  parameter int OUT_TP = 1,
  parameter int DELAY = 2,
  parameter int TCW = 16,
  parameter int TRACE_DEPTH = 512,
  parameter int SCW = 32,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int ICW = $clog2(IN_TP + 1),
  localparam int OCW = $clog2(OUT_TP + 1),
  localparam int TAW = $clog2(TRACE_DEPTH),
  localparam int RW  = TCW + ICW + OCW + CW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enq_valid,
  input  logic [DW-1:0]  enq_data,
  output logic           enq_ok,
  output logic           first_valid,
  output logic [DW-1:0]  first_data,
  input  logic           deq,
  input  logic           prod_commit,
  input  logic           cons_commit,
  output logic           prod_done,
  output logic           cons_done,
  output logic [TCW-1:0] tcycle,
  output logic [CW-1:0]  occupancy,
  output logic [CW-1:0]  peak_occ,
  output logic [SCW-1:0] stall_cnt,
  input  logic           trig,
  input  logic [TAW-1:0] trace_rd_addr,
  output logic [RW-1:0]  trace_rd_data,
  output logic [TAW:0]   trace_count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0]  CNT_MAX = CW'(DEPTH);
  localparam logic [ICW-1:0] IN_MAX  = ICW'(IN_TP);
  localparam logic [OCW-1:0] OUT_MAX = OCW'(OUT_TP);
  localparam logic [TCW-1:0] DLY     = TCW'(DELAY);
  localparam logic [PW-1:0]  PTR_END = PW'(DEPTH - 1);
  localparam logic [TAW:0]   TR_MAX  = (TAW+1)'(TRACE_DEPTH);

  logic [DW-1:0]  slot_d [DEPTH];
  logic [TCW-1:0] slot_t [DEPTH];
  logic [RW-1:0]  tr_mem [TRACE_DEPTH];
  logic [PW-1:0]  rd_p, wr_p;
  logic [ICW-1:0] in_used;
  logic [OCW-1:0] out_used;
  logic           p_seen, c_seen, tr_on;
  logic           adv, deq_fire, tr_wr;
  logic [TCW-1:0] age;

  assign adv         = p_seen & c_seen;
  assign prod_done   = adv;
  assign cons_done   = adv;
  assign enq_ok      = enq_valid & ~p_seen & (occupancy != CNT_MAX) & (in_used != IN_MAX);
  assign age         = tcycle - slot_t[rd_p];
  assign first_valid = (occupancy != '0) & ~c_seen & (out_used != OUT_MAX) & (age >= DLY);
  assign first_data  = slot_d[rd_p];
  assign deq_fire    = deq & first_valid;
  assign tr_wr       = adv & tr_on & (trace_count != TR_MAX);
  assign trace_rd_data = tr_mem[trace_rd_addr];

  always_ff @(posedge clk) begin
    if (enq_ok) begin
      slot_d[wr_p] <= enq_data;
      slot_t[wr_p] <= tcycle;
    end
    if (tr_wr)
      tr_mem[trace_count[TAW-1:0]] <= {tcycle, in_used, out_used, occupancy};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_p <= '0;
      wr_p <= '0;
      occupancy <= '0;
      peak_occ <= '0;
      stall_cnt <= '0;
      tcycle <= '0;
      in_used <= '0;
      out_used <= '0;
      p_seen <= 1'b0;
      c_seen <= 1'b0;
      tr_on <= 1'b0;
      trace_count <= '0;
    end else begin
      if (enq_ok)   wr_p <= (wr_p == PTR_END) ? '0 : wr_p + 1'b1;
      if (deq_fire) rd_p <= (rd_p == PTR_END) ? '0 : rd_p + 1'b1;
      occupancy <= occupancy + CW'(enq_ok) - CW'(deq_fire);
      if (occupancy > peak_occ) peak_occ <= occupancy;
      if (enq_valid & ~p_seen & ~enq_ok) stall_cnt <= stall_cnt + 1'b1;
      if (adv) begin
        tcycle   <= tcycle + 1'b1;
        in_used  <= '0;
        out_used <= '0;
        p_seen   <= 1'b0;
        c_seen   <= 1'b0;
      end else begin
        in_used  <= in_used + ICW'(enq_ok);
        out_used <= out_used + OCW'(deq_fire);
        p_seen   <= p_seen | prod_commit;
        c_seen   <= c_seen | cons_commit;
      end
      if (trig) tr_on <= 1'b1;
      if (tr_wr) trace_count <= trace_count + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) occupancy <= CNT_MAX); // R2
  AST_IN_CAP: assert property (@(posedge clk) disable iff (!rst_n) in_used <= IN_MAX); // R2
  AST_OUT_CAP: assert property (@(posedge clk) disable iff (!rst_n) out_used <= OUT_MAX); // R4
  AST_TCYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n) adv |=> tcycle == $past(tcycle) + 1'b1); // R5
  AST_TCYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !adv |=> $stable(tcycle)); // R6
  AST_BUDGET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) adv |=> (in_used == '0 && out_used == '0)); // R5
  AST_STALL_MONO: assert property (@(posedge clk) disable iff (!rst_n) stall_cnt >= $past(stall_cnt)); // R7
  AST_PEAK_COVERS: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> peak_occ >= $past(occupancy)); // R8
  AST_TRACE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) trace_count <= TR_MAX); // R9
endmodule

// File: tb/tb_tm_delay_link.sv
`timescale 1ns/1ps
module tb_tm_delay_link;
  localparam int DEPTH = 4, IN_TP = 2, OUT_TP = 1, DELAY = 2, TD = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid = 0, deq = 0, prod_commit = 0, cons_commit = 0, trig = 0;
  logic [7:0] enq_data = 0;
  logic [8:0] trace_rd_addr = 0;
  logic enq_ok, first_valid, prod_done, cons_done;
  logic [7:0] first_data;
  logic [15:0] tcycle;
  logic [2:0] occupancy, peak_occ;
  logic [31:0] stall_cnt;
  logic [21:0] trace_rd_data;
  logic [9:0] trace_count;

  always #2.5 clk = ~clk;

  tm_delay_link dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_data(enq_data), .enq_ok(enq_ok),
    .first_valid(first_valid), .first_data(first_data), .deq(deq),
    .prod_commit(prod_commit), .cons_commit(cons_commit), .prod_done(prod_done), .cons_done(cons_done),
    .tcycle(tcycle), .occupancy(occupancy), .peak_occ(peak_occ), .stall_cnt(stall_cnt),
    .trig(trig), .trace_rd_addr(trace_rd_addr), .trace_rd_data(trace_rd_data), .trace_count(trace_count)
  );

  int checks = 0, fails = 0;
  int qd[$], qt[$], recs[$];
  int tc = 0, eu = 0, du = 0, ps = 0, cs = 0, stall = 0, peak = 0, tron = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at tcycle %0d", req, act, exp, tc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int host = 0;
    int ep, dp, cp;
    bit adv, eok, fv, dfire;
    int sz;
    repeat (3) @(negedge clk);
    chk("R1 occupancy", occupancy, 0);
    chk("R1 peak", peak_occ, 0);
    chk("R1 stall", stall_cnt, 0);
    chk("R1 tcycle", tcycle, 0);
    chk("R1 trace_count", trace_count, 0);
    chk("R1 enq_ok", enq_ok, 0);
    chk("R1 first_valid", first_valid, 0);
    chk("R1 done", prod_done | cons_done, 0);
    rst_n = 1'b1;
    while (tc < 540) begin
      @(negedge clk);
      host++;
      if (tc < 150)      begin ep = 90; dp = 30; cp = 40; end
      else if (tc < 300) begin ep = 20; dp = 90; cp = 50; end
      else               begin ep = 60; dp = 60; cp = 30; end
      enq_valid   = ($urandom_range(99) < ep);
      enq_data    = 8'($urandom);
      deq         = ($urandom_range(99) < dp);
      prod_commit = ($urandom_range(99) < cp);
      cons_commit = ($urandom_range(99) < cp);
      trig        = (host == 30);
      #1;
      sz = qd.size();
      chk("R5 tcycle", tcycle, tc);
      chk("R2 occupancy", occupancy, sz);
      chk("R8 peak", peak_occ, peak);
      chk("R7 stall", stall_cnt, stall);
      chk("R9 trace_count", trace_count, recs.size());
      adv = ps && cs;
      chk("R5 prod_done", prod_done, adv);
      chk("R5 cons_done", cons_done, adv);
      eok = enq_valid && !ps && sz < DEPTH && eu < IN_TP;
      chk("R2 enq_ok", enq_ok, eok);
      fv = sz > 0 && !cs && du < OUT_TP && (tc - qt[0]) >= DELAY;
      chk("R3 R4 first_valid", first_valid, fv);
      if (fv && first_valid) chk("R10 first_data", first_data, qd[0]);
      dfire = deq && fv;
      if (enq_valid && !ps && !eok) stall++;
      if (sz > peak) peak = sz;
      if (dfire) begin void'(qd.pop_front()); void'(qt.pop_front()); end
      if (eok) begin qd.push_back(enq_data); qt.push_back(tc); end
      if (adv) begin
        if (tron && recs.size() < TD) recs.push_back(((tc & 16'hFFFF) << 6) | (eu << 4) | (du << 3) | sz);
        tc++; eu = 0; du = 0; ps = 0; cs = 0;
      end else begin
        eu += eok; du += dfire;
        if (prod_commit) ps = 1;
        if (cons_commit) cs = 1;
      end
      if (trig) tron = 1;
    end
    @(negedge clk);
    enq_valid = 0; deq = 0; prod_commit = 0; cons_commit = 0; trig = 0;
    chk("R9 trace full", trace_count, TD);
    for (int i = 0; i < recs.size(); i++) begin
      trace_rd_addr = 9'(i);
      #0.5;
      chk("R9 trace record", trace_rd_data, recs[i]);
    end
    finish_run();
  end
endmodule